// File: doc/BRIEF.md
# Register Scoreboard Issue Gate

This block sits in the issue stage of an in-order pipeline and decides, cycle by cycle, whether the instruction at the head of the decode queue may leave for one of two functional units. It holds a single ready flag for every architectural register. An instruction that is granted clears the flag of the register it will write. A unit that finishes its operation reports the register it wrote, and that flag is set again.

The head instruction is granted only when two conditions hold. First, each of its operand registers is ready or is being written back in this very cycle. Second, its target register has no write still outstanding, which keeps two writes to one register from finishing out of order. A completion that arrives in the same cycle as a waiting operand counts toward the grant, and the block reports which completion port supplies that operand so the datapath can steer the value. While the head waits, everything behind it waits too, because the gate only ever looks at the head.

Register 0 is hard-wired ready. A completion may be reported from each unit in every cycle.

Top module: `sb_issue_gate`

## Requirements
- R1: After reset every ready flag reads 1 on `reg_ready`, and with `head_valid` low neither `issue_gnt` nor `issue_stall` is asserted.
- R2: When the head's operands and target are all clear, `issue_gnt` shows a single 1 at bit `head_unit` in the same cycle, and `issue_stall` stays 0.
- R3: A granted instruction with a nonzero target drives that register's `reg_ready` bit to 0 from the next cycle.
- R4: If any operand register is not ready and no completion names it in that cycle, `issue_gnt` is all zero and `issue_stall` is 1.
- R5: A completion on port p (`cpl_valid[p]` with register `cpl_reg[p*3 +: 3]`) sets that register's `reg_ready` bit from the next cycle, and both ports can do this in the same cycle.
- R6: If the target register is not ready and no completion names it in that cycle, the head stalls, even when all operands are ready.
- R7: An operand that is not ready but is named by a completion in the current cycle counts as ready. On a grant, `byp_sel[s*2 + p]` is 1 for operand s fed by port p. When both ports name that register, only port 0 is flagged. `byp_sel` is all zero whenever there is no grant or the operand's flag was already 1.
- R8: When a granted issue and a completion name the same register in one cycle, that register reads not ready afterwards.
- R9: Register 0 always reads ready. As an operand it never stalls and never selects a bypass, and as a target it is never cleared.
- R10: `issue_stall` equals `head_valid` AND NOT a grant. With `head_valid` low, no grant and no stall occur, and the flags change only through completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A decoded instruction is at the head |
| head_src | input | 6 | Operand register numbers, 3 bits each, operand 0 in the low bits |
| head_dst | input | 3 | Target register number (0 means no write) |
| head_unit | input | 1 | Functional unit the head instruction goes to |
| cpl_valid | input | 2 | Completion report, one bit per unit |
| cpl_reg | input | 6 | Register written by each completion, 3 bits per port |
| issue_gnt | output | 2 | One-hot grant toward the chosen unit |
| issue_stall | output | 1 | Head instruction is held this cycle |
| byp_sel | output | 4 | Per operand, which completion port supplies it |
| reg_ready | output | 8 | Current ready flags of all registers |

## Verification
The bench builds the block at its defaults: eight registers, two operands, two completion ports and two units. With only seven writable registers, random streams often hit a pending operand, a pending target, and two completions landing on one register. They also hit an issue and a completion on the same register in one cycle, so every bypass priority and the clear-wins rule occur many times. Directed sequences cover reset, a dependent stall released by a same-cycle completion, a blocked write-after-write, and register 0 used as both operand and target.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
    localparam int SB_NREGS  = 8;
    localparam int SB_NSRC   = 2;
    localparam int SB_NCPL   = 2;
    localparam int SB_NUNITS = 2;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sb_operand_chk.sv
`timescale 1ns/1ps
module sb_operand_chk #(
    parameter int NUM_REGS = sb_pkg::SB_NREGS,
    parameter int NUM_CPL  = sb_pkg::SB_NCPL,
    localparam int AW      = sb_pkg::idx_bits(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0]   reg_ready,
    input  logic [AW-1:0]         idx,
    input  logic [NUM_CPL-1:0]    cpl_valid,
    input  logic [NUM_CPL*AW-1:0] cpl_reg,
    output logic                  ready,
    output logic [NUM_CPL-1:0]    hit
);
    logic [NUM_CPL-1:0] match;
    logic               pending;

    for (genvar p = 0; p < NUM_CPL; p++) begin : g_match
        assign match[p] = cpl_valid[p] && (cpl_reg[p*AW +: AW] == idx);
    end

    assign pending = (idx != '0) && !reg_ready[idx];

    always_comb begin
        hit = '0;
        if (pending) begin
            for (int p = NUM_CPL - 1; p >= 0; p--) begin
                if (match[p]) begin
                    hit = '0;
                    hit[p] = 1'b1;
                end
            end
        end
        ready = !pending || (|match);
    end
endmodule

// File: rtl/sb_ready_table.sv
`timescale 1ns/1ps
module sb_ready_table #(
    parameter int NUM_REGS = sb_pkg::SB_NREGS,
    parameter int NUM_CPL  = sb_pkg::SB_NCPL,
    localparam int AW      = sb_pkg::idx_bits(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CPL-1:0]    cpl_valid,
    input  logic [NUM_CPL*AW-1:0] cpl_reg,
    input  logic                  clr_en,
    input  logic [AW-1:0]         clr_reg,
    output logic [NUM_REGS-1:0]   reg_ready
);
    typedef struct packed {
        logic [NUM_REGS-1:0] ready;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_CPL; p++) begin
            if (cpl_valid[p]) st_d.ready[cpl_reg[p*AW +: AW]] = 1'b1;
        end
        if (clr_en) st_d.ready[clr_reg] = 1'b0;
        st_d.ready[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ready: '1};
        else        st_q <= st_d;
    end

    assign reg_ready = st_q.ready;

    for (genvar p = 0; p < NUM_CPL; p++) begin : g_cpl_chk
        p_cpl_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_valid[p] && !(clr_en && clr_reg == cpl_reg[p*AW +: AW]))
            |=> reg_ready[$past(cpl_reg[p*AW +: AW])]);
    end

    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_reg != '0) |=> !reg_ready[$past(clr_reg)]);

    p_zero_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready[0]);
endmodule

// File: rtl/sb_issue_gate.sv
`timescale 1ns/1ps
module sb_issue_gate #(
    parameter int NUM_REGS  = sb_pkg::SB_NREGS,
    parameter int NUM_SRC   = sb_pkg::SB_NSRC,
    parameter int NUM_CPL   = sb_pkg::SB_NCPL,
    parameter int NUM_UNITS = sb_pkg::SB_NUNITS,
    localparam int AW       = sb_pkg::idx_bits(NUM_REGS),
    localparam int UW       = sb_pkg::idx_bits(NUM_UNITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          head_valid,
    input  logic [NUM_SRC*AW-1:0]         head_src,
    input  logic [AW-1:0]                 head_dst,
    input  logic [UW-1:0]                 head_unit,
    input  logic [NUM_CPL-1:0]            cpl_valid,
    input  logic [NUM_CPL*AW-1:0]         cpl_reg,
    output logic [NUM_UNITS-1:0]          issue_gnt,
    output logic                          issue_stall,
    output logic [NUM_SRC*NUM_CPL-1:0]    byp_sel,
    output logic [NUM_REGS-1:0]           reg_ready
);
    logic [NUM_SRC-1:0]         src_ok;
    logic [NUM_SRC*NUM_CPL-1:0] src_hit;
    logic                       dst_ok;
    logic [NUM_CPL-1:0]         dst_hit;
    logic                       go;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sb_operand_chk #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_chk (
            .reg_ready (reg_ready),
            .idx       (head_src[s*AW +: AW]),
            .cpl_valid (cpl_valid),
            .cpl_reg   (cpl_reg),
            .ready     (src_ok[s]),
            .hit       (src_hit[s*NUM_CPL +: NUM_CPL])
        );

        p_src_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (head_valid && head_src[s*AW +: AW] != '0 &&
             !reg_ready[head_src[s*AW +: AW]] &&
             !(|src_hit[s*NUM_CPL +: NUM_CPL]))
            |-> (issue_gnt == '0 && issue_stall));
    end

    sb_operand_chk #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_dst_chk (
        .reg_ready (reg_ready),
        .idx       (head_dst),
        .cpl_valid (cpl_valid),
        .cpl_reg   (cpl_reg),
        .ready     (dst_ok),
        .hit       (dst_hit)
    );

    assign go = head_valid && (&src_ok) && dst_ok;

    always_comb begin
        issue_gnt = '0;
        if (go) issue_gnt[head_unit] = 1'b1;
        issue_stall = head_valid && !go;
        byp_sel = go ? src_hit : '0;
    end

    sb_ready_table #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpl_valid (cpl_valid),
        .cpl_reg   (cpl_reg),
        .clr_en    (go),
        .clr_reg   (head_dst),
        .reg_ready (reg_ready)
    );

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_gnt));

    p_waw_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_dst != '0 && !reg_ready[head_dst] && dst_hit == '0)
        |-> (issue_gnt == '0));

    p_byp_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|byp_sel) |-> (|issue_gnt));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> (issue_gnt == '0 && !issue_stall));

    p_grant_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|issue_gnt) && head_dst != '0) |=> !reg_ready[$past(head_dst)]);
endmodule

// File: tb/sim_sb_issue_gate.sv
`timescale 1ns/1ps
module sim_sb_issue_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       head_valid = 1'b0;
    logic [5:0] head_src = '0;
    logic [2:0] head_dst = '0;
    logic       head_unit = 1'b0;
    logic [1:0] cpl_valid = '0;
    logic [5:0] cpl_reg = '0;
    logic [1:0] issue_gnt;
    logic       issue_stall;
    logic [3:0] byp_sel;
    logic [7:0] reg_ready;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] mv;
    bit finished = 0;

    always #4 clk = ~clk;

    sb_issue_gate u0 (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_src(head_src),
        .head_dst(head_dst), .head_unit(head_unit), .cpl_valid(cpl_valid),
        .cpl_reg(cpl_reg), .issue_gnt(issue_gnt), .issue_stall(issue_stall),
        .byp_sel(byp_sel), .reg_ready(reg_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit rdy(input logic [2:0] r, input logic [1:0] cv,
                               input logic [2:0] c0, input logic [2:0] c1);
        return (r == 0) || mv[r] || (cv[0] && c0 == r) || (cv[1] && c1 == r);
    endfunction

    function automatic logic [1:0] bsel(input logic [2:0] r, input logic [1:0] cv,
                                        input logic [2:0] c0, input logic [2:0] c1);
        if (r == 0 || mv[r]) return 2'b00;
        if (cv[0] && c0 == r) return 2'b01;
        if (cv[1] && c1 == r) return 2'b10;
        return 2'b00;
    endfunction

    // drive one cycle, check comb outputs and table, then advance the model
    task automatic step(input bit v, input logic [2:0] s0, input logic [2:0] s1,
                        input logic [2:0] d, input bit u, input logic [1:0] cv,
                        input logic [2:0] c0, input logic [2:0] c1);
        bit go;
        logic [1:0] eg;
        logic [3:0] eb;
        @(negedge clk);
        head_valid = v; head_src = {s1, s0}; head_dst = d; head_unit = u;
        cpl_valid = cv; cpl_reg = {c1, c0};
        #1;
        go = v && rdy(s0, cv, c0, c1) && rdy(s1, cv, c0, c1) && rdy(d, cv, c0, c1);
        eg = go ? (2'b01 << u) : 2'b00;
        eb = go ? {bsel(s1, cv, c0, c1), bsel(s0, cv, c0, c1)} : 4'b0;
        chk("R3 R5 R8 R9 ready table", {24'b0, reg_ready}, {24'b0, mv});
        chk("R2 R4 R6 issue_gnt", {30'b0, issue_gnt}, {30'b0, eg});
        chk("R10 issue_stall", {31'b0, issue_stall}, {31'b0, v && !go});
        chk("R7 byp_sel", {28'b0, byp_sel}, {28'b0, eb});
        if (cv[0]) mv[c0] = 1'b1;
        if (cv[1]) mv[c1] = 1'b1;
        if (go) mv[d] = 1'b0;
        mv[0] = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250));
        mv = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 reset ready", {24'b0, reg_ready}, 32'hFF);
        chk("R1 reset gnt", {30'b0, issue_gnt}, 32'h0);
        chk("R1 reset stall", {31'b0, issue_stall}, 32'h0);

        // R2/R3: issue r3 <- r2,r2 on unit 1
        step(1, 3'd2, 3'd2, 3'd3, 1, 2'b00, 3'd0, 3'd0);
        // R4: dependent on r3 stalls, repeated (in-order hold)
        step(1, 3'd3, 3'd6, 3'd5, 0, 2'b00, 3'd0, 3'd0);
        step(1, 3'd3, 3'd6, 3'd5, 0, 2'b00, 3'd0, 3'd0);
        // R7: r3 completes on port 1 this cycle, dependent issues with bypass
        step(1, 3'd3, 3'd6, 3'd5, 0, 2'b10, 3'd0, 3'd3);
        // R6: r5 pending, write to r5 again blocked
        step(1, 3'd1, 3'd2, 3'd5, 1, 2'b00, 3'd0, 3'd0);
        // R7 priority: both ports complete r5 with dependent waiting -> port 0
        step(1, 3'd5, 3'd5, 3'd4, 0, 2'b11, 3'd5, 3'd5);
        // R8: issue to r4 while r4 completes
        step(1, 3'd1, 3'd1, 3'd4, 1, 2'b01, 3'd4, 3'd0);
        // R9: register 0 as operand and target
        step(1, 3'd0, 3'd0, 3'd0, 0, 2'b00, 3'd0, 3'd0);
        // R10: idle head, completion of r4 only
        step(0, 3'd4, 3'd4, 3'd4, 0, 2'b01, 3'd4, 3'd0);
        step(0, 3'd0, 3'd0, 3'd0, 0, 2'b00, 3'd0, 3'd0);

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 5) != 0, 3'($urandom), 3'($urandom), 3'($urandom),
                 1'($urandom), 2'($urandom), 3'($urandom), 3'($urandom));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule